// File: doc/BRIEF.md
# Eight-Level Programmable Interrupt Controller

This block gathers eight interrupt request lines, ranks the pending ones and raises a single interrupt output toward a processor. When the processor acknowledges, the block drives a vector byte onto its data output. The vector combines a programmed base with the 3-bit number of the winning level, and the block records that level as in service. A host programs the block through a byte-wide register port: chip select, read and write strobes, one address bit and an 8-bit bus.

Setup starts with an initialization sequence, which fixes the trigger style, the vector base and the end-of-interrupt style. After that, operation commands control how the ranking works. Fully nested order puts level 0 on top. Rotation can be automatic or set by software. Special mask mode lets other levels pre-empt, and poll mode lets the processor read the winner without an interrupt. End-of-interrupt can be specific, non-specific or automatic.

All register writes are single-cycle strobes sampled on the rising clock: a write takes effect when `cs_n` and `wr_n` are both low at a clock edge. The host port is a plain register interface with no back-pressure, so every strobe is accepted in the cycle it appears. `dout` is combinational. `inta` is a one-cycle, active-high acknowledge pulse.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset, `int_o` is low and the mask reads 0. `int_o` stays low until initialization completes. An initialization-start write (address 0, data bit 4 set) clears the mask, the in-service register and the rotation, so level 0 is on top again. It also selects the request register for reads.
- R2: Bit 3 of the start word selects level triggering when set. A level-triggered request register follows the input, so it clears when the line drops. An edge-triggered request bit is set by a 0-to-1 transition and stays set until it is acknowledged.
- R3: Once initialization is done, a write at address 1 loads the mask and a read at address 1 returns it. A set mask bit keeps that level from raising `int_o`, while its request bit still latches.
- R4: In the default order, level 0 ranks highest and level 7 lowest. An in-service level blocks requests at the same or lower rank from raising `int_o`.
- R5: An acknowledge returns the vector `{base[7:3], level}` on `dout`. Here `base` is the second initialization word. The acknowledge sets the winner's in-service bit and clears its request bit.
- R6: The command 0x20 clears the highest-ranked in-service bit (non-specific end). The command 0x60|L clears in-service bit L (specific end).
- R7: When bit 1 of the fourth initialization word is set, an acknowledge leaves no in-service bit set (automatic end).
- R8: The command 0xA0 does a non-specific end and makes the cleared level the lowest rank. After 0x80, each automatic-end acknowledge makes the acknowledged level the lowest. The command 0x00 turns that off.
- R9: The command 0xC0|L makes level L the lowest rank, with L+1 (mod 8) the highest.
- R10: The command 0x68 enters special mask mode, where an in-service level blocks only itself. The command 0x48 leaves it.
- R11: The command 0x0C enters poll mode, which holds `int_o` low. An address-0 read then returns bit 7 set when a level would win, with that level's number in bits 2:0. Any command at address 0 with bits 4:3 = 01 and bit 2 clear leaves poll mode.
- R12: The command 0x0A makes address-0 reads return the request register. The command 0x0B makes them return the in-service register.
- R13: Bit 1 of the start word set means no third word. Bit 0 set means a fourth word follows. The next address-1 write after the last expected word is a mask write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| a0 | input | 1 | Register address bit |
| din | input | 8 | Host write data |
| dout | output | 8 | Read data, or vector during acknowledge |
| irq_in | input | 8 | Interrupt request lines |
| int_o | output | 1 | Interrupt to processor |
| inta | input | 1 | Acknowledge pulse, active high |

## Verification
Directed runs check several request shapes against each other. A pair of pulsed levels with one in service separates nested blocking from special-mask pre-emption. The same pair after a rotation command shows whether the ranking origin moved. A held line, then dropped, separates level triggering from an edge latch. A random phase then applies sparse masks, random lowest-rank settings, random special-mask state and random multi-bit pulses. It predicts `int_o`, the vector and both readable registers from a bench model. A wrong rank, a missed block or a stale request bit would therefore show up as a mismatch in one of those four values.

// File: rtl/irq8_pkg.sv
package irq8_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_W2    = 3'd1,
    ST_W3    = 3'd2,
    ST_W4    = 3'd3,
    ST_READY = 3'd4
  } init_st_e;

  typedef enum logic [2:0] {
    OP_ROT_AEOI_OFF = 3'b000,
    OP_NS_EOI       = 3'b001,
    OP_NOP          = 3'b010,
    OP_SP_EOI       = 3'b011,
    OP_ROT_AEOI_ON  = 3'b100,
    OP_ROT_NS_EOI   = 3'b101,
    OP_SET_LOW      = 3'b110,
    OP_ROT_SP_EOI   = 3'b111
  } ocw2_op_e;
endpackage

// File: rtl/irq8_reqlatch.sv
module irq8_reqlatch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_all,
  input  logic         level_mode,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] irr
);
  logic [N-1:0] irq_q;

  for (genvar i = 0; i < N; i++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irq_q[i] <= 1'b0;
        irr[i]   <= 1'b0;
      end else begin
        irq_q[i] <= irq_in[i];
        if (clr_all || ack_clr[i])
          irr[i] <= 1'b0;
        else if (level_mode)
          irr[i] <= irq_in[i];
        else if (irq_in[i] && !irq_q[i])
          irr[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq8_resolver.sv
module irq8_resolver #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  isr,
  input  logic          smm,
  input  logic [LW-1:0] lowest,
  output logic          grant_vld,
  output logic [LW-1:0] grant_lvl,
  output logic          top_isr_vld,
  output logic [LW-1:0] top_isr_lvl
);
  logic [LW-1:0] lv;
  logic          stop;

  // Walk levels from highest to lowest rank: lowest+1, lowest+2, ...
  always_comb begin
    grant_vld   = 1'b0;
    grant_lvl   = '0;
    top_isr_vld = 1'b0;
    top_isr_lvl = '0;
    stop        = 1'b0;
    lv          = '0;
    for (int k = 0; k < N; k++) begin
      lv = lowest + LW'(1) + LW'(k);
      if (!stop) begin
        if (isr[lv] && !smm) begin
          stop = 1'b1;
        end else if (req[lv] && !isr[lv]) begin
          stop      = 1'b1;
          grant_vld = 1'b1;
          grant_lvl = lv;
        end
      end
      if (!top_isr_vld && isr[lv]) begin
        top_isr_vld = 1'b1;
        top_isr_lvl = lv;
      end
    end
  end
endmodule

// File: rtl/irq8_host.sv
module irq8_host
  import irq8_pkg::*;
#(
  parameter int N  = 8,
  parameter int LW = $clog2(N),
  parameter int BW = 8 - LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          a0,
  input  logic [7:0]    din,
  input  logic          isr_vld,
  input  logic [LW-1:0] isr_lvl,
  output logic          ready,
  output logic          init_pulse,
  output logic [N-1:0]  imr,
  output logic [BW-1:0] base,
  output logic          level_mode,
  output logic          aeoi,
  output logic          rot_aeoi,
  output logic          smm,
  output logic          poll,
  output logic          rsel_isr,
  output logic [N-1:0]  eoi_clr,
  output logic          rot_vld,
  output logic [LW-1:0] rot_lvl
);
  init_st_e st;
  logic     need_w4;
  logic     single;
  logic     ocw2_hit;
  logic     ocw3_hit;
  ocw2_op_e op;

  assign ready      = (st == ST_READY);
  assign init_pulse = wr_en && !a0 && din[4];
  assign ocw2_hit   = wr_en && !a0 && !din[4] && !din[3] && ready;
  assign ocw3_hit   = wr_en && !a0 && !din[4] &&  din[3] && ready;
  assign op         = ocw2_op_e'(din[7:5]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      need_w4    <= 1'b0;
      single     <= 1'b1;
      imr        <= '0;
      base       <= '0;
      level_mode <= 1'b0;
      aeoi       <= 1'b0;
      rot_aeoi   <= 1'b0;
      smm        <= 1'b0;
      poll       <= 1'b0;
      rsel_isr   <= 1'b0;
    end else if (init_pulse) begin
      st         <= ST_W2;
      need_w4    <= din[0];
      single     <= din[1];
      level_mode <= din[3];
      imr        <= '0;
      aeoi       <= 1'b0;
      rot_aeoi   <= 1'b0;
      smm        <= 1'b0;
      poll       <= 1'b0;
      rsel_isr   <= 1'b0;
    end else if (wr_en && a0) begin
      unique case (st)
        ST_W2: begin
          base <= din[7:LW];
          if (!single)     st <= ST_W3;
          else if (need_w4) st <= ST_W4;
          else              st <= ST_READY;
        end
        ST_W3:    st <= need_w4 ? ST_W4 : ST_READY;
        ST_W4: begin
          aeoi <= din[1];
          st   <= ST_READY;
        end
        ST_READY: imr <= din[N-1:0];
        default:  st <= st;
      endcase
    end else if (ocw3_hit) begin
      if (din[6]) smm <= din[5];
      poll <= din[2];
      if (din[1]) rsel_isr <= din[0];
    end else if (ocw2_hit) begin
      if (op == OP_ROT_AEOI_ON)  rot_aeoi <= 1'b1;
      if (op == OP_ROT_AEOI_OFF) rot_aeoi <= 1'b0;
    end
  end

  always_comb begin
    eoi_clr = '0;
    rot_vld = 1'b0;
    rot_lvl = din[LW-1:0];
    if (ocw2_hit) begin
      unique case (op)
        OP_NS_EOI: if (isr_vld) eoi_clr[isr_lvl] = 1'b1;
        OP_SP_EOI: eoi_clr[din[LW-1:0]] = 1'b1;
        OP_ROT_NS_EOI: if (isr_vld) begin
          eoi_clr[isr_lvl] = 1'b1;
          rot_vld          = 1'b1;
          rot_lvl          = isr_lvl;
        end
        OP_ROT_SP_EOI: begin
          eoi_clr[din[LW-1:0]] = 1'b1;
          rot_vld              = 1'b1;
        end
        OP_SET_LOW: rot_vld = 1'b1;
        default: rot_vld = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8
  import irq8_pkg::*;
#(
  parameter int N = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       a0,
  input  logic [7:0] din,
  output logic [7:0] dout,
  input  logic [7:0] irq_in,
  output logic       int_o,
  input  logic       inta
);
  localparam int LW = $clog2(N);
  localparam int BW = 8 - LW;

  logic          wr_en;
  logic          ready, init_pulse, level_mode, aeoi, rot_aeoi, smm, poll, rsel_isr;
  logic [N-1:0]  imr, irr, isr, eoi_clr, ack_clr, isr_set;
  logic [BW-1:0] base;
  logic          rot_vld;
  logic [LW-1:0] rot_lvl, lowest;
  logic          grant_vld, top_isr_vld;
  logic [LW-1:0] grant_lvl, top_isr_lvl;
  logic          ack_fire;
  logic [7:0]    rdata, vec;

  assign wr_en = !cs_n && !wr_n;

  irq8_host #(.N(N)) u_host (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .a0(a0), .din(din),
    .isr_vld(top_isr_vld), .isr_lvl(top_isr_lvl),
    .ready(ready), .init_pulse(init_pulse), .imr(imr), .base(base),
    .level_mode(level_mode), .aeoi(aeoi), .rot_aeoi(rot_aeoi), .smm(smm),
    .poll(poll), .rsel_isr(rsel_isr), .eoi_clr(eoi_clr),
    .rot_vld(rot_vld), .rot_lvl(rot_lvl)
  );

  irq8_reqlatch #(.N(N)) u_req (
    .clk(clk), .rst_n(rst_n), .clr_all(init_pulse), .level_mode(level_mode),
    .irq_in(irq_in[N-1:0]), .ack_clr(ack_clr), .irr(irr)
  );

  irq8_resolver #(.N(N)) u_res (
    .req(irr & ~imr), .isr(isr), .smm(smm), .lowest(lowest),
    .grant_vld(grant_vld), .grant_lvl(grant_lvl),
    .top_isr_vld(top_isr_vld), .top_isr_lvl(top_isr_lvl)
  );

  assign int_o    = ready && !poll && grant_vld;
  assign ack_fire = inta && int_o;

  always_comb begin
    ack_clr = '0;
    isr_set = '0;
    if (ack_fire) begin
      ack_clr[grant_lvl] = 1'b1;
      if (!aeoi) isr_set[grant_lvl] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr    <= '0;
      lowest <= LW'(N - 1);
    end else if (init_pulse) begin
      isr    <= '0;
      lowest <= LW'(N - 1);
    end else begin
      isr <= (isr | isr_set) & ~eoi_clr;
      if (rot_vld)
        lowest <= rot_lvl;
      else if (ack_fire && aeoi && rot_aeoi)
        lowest <= grant_lvl;
    end
  end

  assign vec = {base, grant_lvl};

  always_comb begin
    if (a0)
      rdata = 8'(imr);
    else if (poll)
      rdata = {grant_vld, 4'b0000, 3'(grant_lvl)};
    else if (rsel_isr)
      rdata = 8'(isr);
    else
      rdata = 8'(irr);
  end

  assign dout = inta ? vec : rdata;

  logic unused_rd;
  assign unused_rd = rd_n;
endmodule

// File: rtl/irq8_checker.sv
module irq8_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       a0,
  input logic [7:0] din,
  input logic [7:0] dout,
  input logic       inta,
  input logic       int_o,
  input logic       ready,
  input logic       poll,
  input logic       aeoi,
  input logic [7:0] imr,
  input logic [7:0] irr,
  input logic [7:0] isr,
  input logic [4:0] base
);
  p_poll_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    poll |-> !int_o);

  p_mask_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> ((irr & ~imr) != 8'h00));

  p_mask_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && a0 && ready) |=> (imr == $past(din)));

  p_vec_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inta |-> (dout[7:3] == base));

  p_ack_isr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && int_o && !aeoi && !wr_en) |=> isr[$past(dout[2:0])]);

  p_aeoi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && int_o && aeoi && !wr_en) |=> (isr == $past(isr)));

  p_quiet_uninit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !int_o);
endmodule

bind irq_ctrl8 irq8_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .a0(a0), .din(din), .dout(dout),
  .inta(inta), .int_o(int_o), .ready(ready), .poll(poll), .aeoi(aeoi),
  .imr(imr), .irr(irr), .isr(isr), .base(base)
);

// File: tb/irq_ctrl8_bench.sv
module irq_ctrl8_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0, inta = 1'b0;
  logic [7:0] din = '0, irq_in = '0;
  logic [7:0] dout;
  logic       int_o;
  int         vectors = 0, miscompares = 0;
  bit         done = 1'b0;
  logic [7:0] v;

  always #5 clk = ~clk;

  irq_ctrl8 u_irq_ctrl8 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .a0(a0),
    .din(din), .dout(dout), .irq_in(irq_in), .int_o(int_o), .inta(inta)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); cs_n = 0; wr_n = 0; a0 = a; din = d;
    @(negedge clk); cs_n = 1; wr_n = 1;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    @(negedge clk); cs_n = 0; rd_n = 0; a0 = a; #1 d = dout;
    cs_n = 1; rd_n = 1;
  endtask

  task automatic ack(output logic [7:0] d);
    @(negedge clk); inta = 1; #1 d = dout;
    @(negedge clk); inta = 0;
  endtask

  task automatic pulse(logic [7:0] p);
    @(negedge clk); irq_in = p;
    @(negedge clk); irq_in = '0;
  endtask

  task automatic intchk(string req, logic exp);
    @(negedge clk); #1 chk(req, {7'd0, int_o}, {7'd0, exp});
  endtask

  task automatic init(logic [7:0] w1, logic [7:0] w2, logic [7:0] w4);
    wr(0, w1); wr(1, w2);
    if (!w1[1]) wr(1, 8'h00);
    if (w1[0]) wr(1, w4);
  endtask

  // Bench model of the ranking rules (R4, R9, R10)
  function automatic logic [3:0] m_pick(logic [7:0] req, logic [7:0] isr,
                                        logic [2:0] low, logic smm);
    logic [2:0] lv;
    m_pick = 4'h0;
    for (int k = 0; k < 8; k++) begin
      lv = low + 3'd1 + 3'(k);
      if (isr[lv] && !smm) break;
      if (req[lv] && !isr[lv]) begin m_pick = {1'b1, lv}; break; end
    end
  endfunction

  function automatic logic [3:0] m_top(logic [7:0] isr, logic [2:0] low);
    logic [2:0] lv;
    m_top = 4'h0;
    for (int k = 0; k < 8; k++) begin
      lv = low + 3'd1 + 3'(k);
      if (isr[lv]) begin m_top = {1'b1, lv}; break; end
    end
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL WDOG actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] irr_m, isr_m, mask;
    logic [2:0] low;
    logic       smm;
    logic [3:0] e;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    intchk("R1 reset int", 1'b0);
    rd(1, v); chk("R1 reset mask", v, 8'h00);

    // R13: single, fourth word present
    init(8'h13, 8'h40, 8'h01);
    rd(1, v); chk("R1 mask after init", v, 8'h00);
    wr(1, 8'hA5); rd(1, v); chk("R13 mask after 3-word init", v, 8'hA5);
    // R13: third word expected
    init(8'h11, 8'h40, 8'h01);
    rd(1, v); chk("R1 init clears mask", v, 8'h00);
    wr(1, 8'h3C); rd(1, v); chk("R13 mask after 4-word init", v, 8'h3C);
    wr(1, 8'h00);

    // R4 nested ordering and blocking
    pulse(8'h48); intchk("R4 int", 1'b1);
    ack(v); chk("R5 vector lvl3", v, 8'h43);
    intchk("R4 lvl6 blocked by lvl3", 1'b0);
    pulse(8'h02); intchk("R4 lvl1 pre-empts", 1'b1);
    ack(v); chk("R5 vector lvl1", v, 8'h41);
    wr(0, 8'h0B); rd(0, v); chk("R12 isr read", v, 8'h0A);
    wr(0, 8'h20); rd(0, v); chk("R6 non-specific EOI", v, 8'h08);
    intchk("R4 still blocked", 1'b0);
    wr(0, 8'h63); rd(0, v); chk("R6 specific EOI", v, 8'h00);
    intchk("R4 lvl6 now open", 1'b1);
    ack(v); chk("R5 vector lvl6", v, 8'h46);
    wr(0, 8'h0A); rd(0, v); chk("R5 irr cleared on ack", v, 8'h00);
    wr(0, 8'h66);

    // R3 mask, R2 edge latch
    wr(1, 8'h04); pulse(8'h04); intchk("R3 masked", 1'b0);
    rd(0, v); chk("R3 R2 irr latched while masked", v, 8'h04);
    wr(1, 8'h00); intchk("R3 unmasked", 1'b1);
    ack(v); chk("R3 vector", v, 8'h42); wr(0, 8'h62);

    // R8 rotation on non-specific EOI
    pulse(8'h10); ack(v); chk("R8 vector lvl4", v, 8'h44);
    wr(0, 8'hA0);
    pulse(8'h28); ack(v); chk("R8 lvl5 above lvl3 after rotate", v, 8'h45);
    wr(0, 8'h20); ack(v); chk("R8 lvl3 next", v, 8'h43); wr(0, 8'h20);

    // R9 set lowest
    wr(0, 8'hC6); pulse(8'h81); ack(v); chk("R9 lvl7 on top", v, 8'h47);
    wr(0, 8'h67); ack(v); chk("R9 lvl0 next", v, 8'h40); wr(0, 8'h60);
    wr(0, 8'hC7);

    // R10 special mask
    wr(0, 8'h68); pulse(8'h20); ack(v); chk("R10 lvl5", v, 8'h45);
    pulse(8'h40); intchk("R10 lower level allowed", 1'b1);
    ack(v); chk("R10 lvl6 vector", v, 8'h46);
    pulse(8'h20); intchk("R10 own level blocked", 1'b0);
    wr(0, 8'h48); wr(0, 8'h65); wr(0, 8'h66);
    intchk("R10 lvl5 after EOI", 1'b1);
    ack(v); chk("R10 lvl5 again", v, 8'h45); wr(0, 8'h65);

    // R11 poll
    pulse(8'h44); wr(0, 8'h0C); intchk("R11 int suppressed", 1'b0);
    rd(0, v); chk("R11 poll byte", v, 8'h82);
    wr(0, 8'h08); intchk("R11 int after poll exit", 1'b1);
    ack(v); chk("R11 vector", v, 8'h42); wr(0, 8'h20);
    ack(v); chk("R11 vector lvl6", v, 8'h46); wr(0, 8'h20);
    wr(0, 8'h0C); rd(0, v); chk("R11 poll empty", v, 8'h00); wr(0, 8'h08);

    // R7 automatic EOI, R8 rotate in automatic mode
    init(8'h13, 8'h80, 8'h03);
    pulse(8'h02); ack(v); chk("R7 vector", v, 8'h81);
    wr(0, 8'h0B); rd(0, v); chk("R7 isr empty", v, 8'h00);
    wr(0, 8'h80);
    pulse(8'h04); ack(v); chk("R8 aeoi lvl2", v, 8'h82);
    pulse(8'h0A); ack(v); chk("R8 lvl3 above lvl1", v, 8'h83);
    ack(v); chk("R8 lvl1 last", v, 8'h81);
    wr(0, 8'h00);

    // R2 level triggering
    init(8'h1B, 8'h40, 8'h01);
    @(negedge clk); irq_in = 8'h04;
    rd(0, v); chk("R2 level irr", v, 8'h04);
    intchk("R2 level int", 1'b1);
    ack(v); chk("R2 vector", v, 8'h42);
    intchk("R4 same level blocked", 1'b0);
    @(negedge clk); irq_in = 8'h00;
    rd(0, v); chk("R2 level irr follows line", v, 8'h00);
    wr(0, 8'h62); intchk("R2 no stale request", 1'b0);

    // Random phase
    init(8'h13, 8'h40, 8'h01);
    irr_m = '0; isr_m = '0;
    for (int it = 0; it < 150; it++) begin
      logic [7:0] pat;
      pat  = 8'($urandom);
      mask = 8'($urandom) & 8'($urandom);
      low  = 3'($urandom % 8);
      smm  = 1'($urandom % 2);
      wr(1, mask); wr(0, 8'hC0 | 8'(low)); wr(0, smm ? 8'h68 : 8'h48);
      pulse(pat); irr_m |= pat;
      e = m_pick(irr_m & ~mask, isr_m, low, smm);
      intchk("R4 R10 rnd int", e[3]);
      if (e[3]) begin
        ack(v); chk("R5 R9 rnd vector", v, 8'h40 | 8'(e[2:0]));
        irr_m[e[2:0]] = 1'b0; isr_m[e[2:0]] = 1'b1;
      end
      wr(0, 8'h0A); rd(0, v); chk("R12 rnd irr", v, irr_m);
      wr(0, 8'h0B); rd(0, v); chk("R12 rnd isr", v, isr_m);
      if ($urandom % 2 == 0) begin
        e = m_top(isr_m, low);
        if (e[3]) isr_m[e[2:0]] = 1'b0;
        wr(0, 8'h20);
      end else if (isr_m != 0) begin
        logic [2:0] j;
        j = 3'($urandom % 8);
        isr_m[j] = 1'b0;
        wr(0, 8'h60 | 8'(j));
      end
      rd(0, v); chk("R6 rnd isr after EOI", v, isr_m);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule